// File: doc/BRIEF.md
# Interleaved IQ Input Port Steering

This block accepts 16-bit sample words for a two-channel DAC data path and delivers aligned I/Q pairs with a one-cycle valid pulse. A static mode input selects between two arrangements. In parallel mode, the I word and the Q word arrive on two separate buses in the same cycle, and the framing strobe acts as the enable for the path. In interleaved mode, one bus carries I and Q words in alternation, and the strobe level of each word decides which channel the word belongs to.

In interleaved mode, an order input chooses which word of each pair arrives first. The block then holds that word until its partner arrives. If the strobe repeats a level where it should alternate, the block drops the partial pair, starts a new pair from the current word where possible, and sets a sticky error flag. Software clears this flag with a clear pulse.

Every input is registered on the rising clock edge. The configuration bits travel with the data, so a change of mode or order takes effect at a word boundary. Such a change discards any half-built pair.

Top module: `iq_port_steer`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge clears `i_out`, `q_out`, `out_valid` and `frame_err` to 0.
- R2: With `cfg_single`=0, a cycle in which `frame_stb`=1 puts `bus_a` on `i_out` and `bus_b` on `q_out`. These values appear two clock edges after they are presented (one capture edge, then the output edge), together with a one-cycle `out_valid`=1. No strobe level in this mode sets `frame_err`.
- R3: With `cfg_single`=0, a cycle in which `frame_stb`=0 produces no `out_valid`. Whenever `out_valid` is 0, `i_out` and `q_out` keep their last values.
- R4: With `cfg_single`=1, only `bus_a` is used. A word taken with `frame_stb`=1 is an I word, a word taken with `frame_stb`=0 is a Q word, and `bus_b` has no effect on the outputs.
- R5: With `cfg_single`=1 and `cfg_q_first`=0, a pair is a strobe-low word followed by a strobe-high word. The pair appears, with `out_valid`, two edges after the second word is presented.
- R6: With `cfg_single`=1 and `cfg_q_first`=1, a pair is a strobe-high word followed by a strobe-low word. Timing is the same as in R5.
- R7: In interleaved mode, `out_valid` is never high in two consecutive cycles. A strobe that alternates without a break yields one pair every two cycles.
- R8: In interleaved mode, a word whose strobe level equals that of the previous word sets `frame_err` one edge after the word is captured. A repeated leading-level word replaces the held word. A repeated trailing-level word is discarded. No pair is emitted for the erroneous word.
- R9: `frame_err` stays at 1 until a cycle with `err_clr`=1. If a new error and `err_clr` fall on the same edge, the flag stays at 1.
- R10: A change of `cfg_single` or `cfg_q_first` discards any held word and the previous strobe level. The first word under the new setting starts afresh, and comparing its level with the word before the change raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock; everything samples on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_single | input | 1 | 0 = two parallel buses, 1 = interleaved on `bus_a` |
| cfg_q_first | input | 1 | Pair order in interleaved mode: 0 = low-strobe word first, 1 = high-strobe word first |
| err_clr | input | 1 | Clears the sticky framing error |
| frame_stb | input | 1 | Channel steering (interleaved) or path enable (parallel) |
| bus_a | input | W | Bus 1: I word (parallel) or every word (interleaved) |
| bus_b | input | W | Bus 2: Q word in parallel mode |
| i_out | output | W | I sample of the last pair |
| q_out | output | W | Q sample of the last pair |
| out_valid | output | 1 | One-cycle pulse marking a new pair |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
A framing error being recorded and a software clear of the flag can land on the same clock edge. The bench provokes this by feeding two strobe-low words in a row and raising `err_clr` for exactly the edge on which the error from the second word is registered. It then requires `frame_err` to still read 1, and to drop only after a later clear that comes alone. Configuration changes made in the middle of a pair are judged through the scoreboard. A pair that the old setting would have completed must not appear, and the next pair must carry the word that follows the change.

// File: rtl/iq_steer_pkg.sv
package iq_steer_pkg;

  typedef struct packed {
    logic single;   // interleaved mode
    logic q_first;  // pair order
  } cfg_t;

  // A word leads its pair when its strobe level equals the order bit:
  // order 0 leads with the low-strobe word, order 1 with the high-strobe word.
  function automatic logic leads_pair(input logic lvl, input logic q_first);
    return lvl == q_first;
  endfunction

  // Two consecutive interleaved words with the same level break framing.
  function automatic logic level_repeats(input logic lvl, input logic prev_lvl,
                                         input logic prev_known);
    return prev_known && (lvl == prev_lvl);
  endfunction

endpackage

// File: rtl/iq_capture.sv
module iq_capture
  import iq_steer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cfg_t         cfg_in,
  input  logic         stb_in,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output cfg_t         cap_cfg,
  output logic         cap_stb,
  output logic [W-1:0] cap_a,
  output logic [W-1:0] cap_b,
  output logic         cap_vld
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_cfg <= '0;
      cap_stb <= 1'b0;
      cap_a   <= '0;
      cap_b   <= '0;
      cap_vld <= 1'b0;
    end else begin
      cap_cfg <= cfg_in;
      cap_stb <= stb_in;
      cap_a   <= a_in;
      cap_b   <= b_in;
      cap_vld <= 1'b1;
    end
  end

endmodule

// File: rtl/iq_pair_asm.sv
module iq_pair_asm
  import iq_steer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cfg_t         cap_cfg,
  input  logic         cap_stb,
  input  logic [W-1:0] cap_a,
  input  logic [W-1:0] cap_b,
  input  logic         cap_vld,
  output logic [W-1:0] i_out,
  output logic [W-1:0] q_out,
  output logic         out_valid,
  output logic         err_set
);

  logic [W-1:0] held;
  logic         have_lead;
  logic         prev_lvl;
  logic         prev_known;
  cfg_t         cfg_q;
  logic         cfg_seen;

  // named internal events
  logic         cfg_chg;
  logic         fresh;
  logic         is_lead;
  logic         rep;
  logic         emit;
  logic [W-1:0] i_nxt;
  logic [W-1:0] q_nxt;

  always_comb begin
    cfg_chg = cap_vld && cfg_seen && (cap_cfg != cfg_q);
    fresh   = !cfg_seen || cfg_chg;
    is_lead = leads_pair(cap_stb, cap_cfg.q_first);
    rep     = !fresh && level_repeats(cap_stb, prev_lvl, prev_known);
    err_set = cap_vld && cap_cfg.single && rep;
    if (cap_cfg.single)
      emit = cap_vld && !is_lead && have_lead && !fresh;
    else
      emit = cap_vld && cap_stb;
    if (cap_cfg.single) begin
      i_nxt = cap_cfg.q_first ? held  : cap_a;
      q_nxt = cap_cfg.q_first ? cap_a : held;
    end else begin
      i_nxt = cap_a;
      q_nxt = cap_b;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held       <= '0;
      have_lead  <= 1'b0;
      prev_lvl   <= 1'b0;
      prev_known <= 1'b0;
      cfg_q      <= '0;
      cfg_seen   <= 1'b0;
      i_out      <= '0;
      q_out      <= '0;
      out_valid  <= 1'b0;
    end else begin
      out_valid <= emit;
      if (emit) begin
        i_out <= i_nxt;
        q_out <= q_nxt;
      end
      if (cap_vld) begin
        cfg_q    <= cap_cfg;
        cfg_seen <= 1'b1;
        if (cap_cfg.single) begin
          prev_lvl   <= cap_stb;
          prev_known <= 1'b1;
          if (is_lead) begin
            held      <= cap_a;
            have_lead <= 1'b1;
          end else begin
            have_lead <= 1'b0;
          end
        end else begin
          have_lead  <= 1'b0;
          prev_known <= 1'b0;
        end
      end
    end
  end

  // R7
  single_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_q.single) |=> !(out_valid && cfg_q.single));

  // R3
  dual_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_vld && !cap_cfg.single && !cap_stb) |=> !out_valid);

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_chg && cap_cfg.single) |=> !out_valid);

  // R8
  err_no_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> !out_valid);

endmodule

// File: rtl/iq_err_flag.sv
module iq_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic err_set,
  input  logic err_clr,
  output logic frame_err
);

  always_ff @(posedge clk) begin
    if (!rst_n)
      frame_err <= 1'b0;
    else if (err_set)
      frame_err <= 1'b1;
    else if (err_clr)
      frame_err <= 1'b0;
  end

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err && !err_clr) |=> frame_err);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> frame_err);

endmodule

// File: rtl/iq_port_steer.sv
module iq_port_steer
  import iq_steer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_single,
  input  logic         cfg_q_first,
  input  logic         err_clr,
  input  logic         frame_stb,
  input  logic [W-1:0] bus_a,
  input  logic [W-1:0] bus_b,
  output logic [W-1:0] i_out,
  output logic [W-1:0] q_out,
  output logic         out_valid,
  output logic         frame_err
);

  cfg_t         cfg_in;
  cfg_t         cap_cfg;
  logic         cap_stb;
  logic [W-1:0] cap_a;
  logic [W-1:0] cap_b;
  logic         cap_vld;
  logic         err_set;

  assign cfg_in = '{single: cfg_single, q_first: cfg_q_first};

  iq_capture #(.W(W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cfg_in(cfg_in), .stb_in(frame_stb),
    .a_in(bus_a), .b_in(bus_b), .cap_cfg(cap_cfg), .cap_stb(cap_stb),
    .cap_a(cap_a), .cap_b(cap_b), .cap_vld(cap_vld)
  );

  iq_pair_asm #(.W(W)) u_asm (
    .clk(clk), .rst_n(rst_n), .cap_cfg(cap_cfg), .cap_stb(cap_stb),
    .cap_a(cap_a), .cap_b(cap_b), .cap_vld(cap_vld),
    .i_out(i_out), .q_out(q_out), .out_valid(out_valid), .err_set(err_set)
  );

  iq_err_flag u_err (
    .clk(clk), .rst_n(rst_n), .err_set(err_set), .err_clr(err_clr),
    .frame_err(frame_err)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !frame_err));

endmodule

// File: tb/sim_iq_port_steer.sv
module sim_iq_port_steer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_single = 1'b0;
  logic        cfg_q_first = 1'b0;
  logic        err_clr = 1'b0;
  logic        frame_stb = 1'b0;
  logic [15:0] bus_a = '0;
  logic [15:0] bus_b = '0;
  logic [15:0] i_out, q_out;
  logic        out_valid, frame_err;

  always #2ns clk = ~clk;

  iq_port_steer #(.W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_single(cfg_single), .cfg_q_first(cfg_q_first),
    .err_clr(err_clr), .frame_stb(frame_stb), .bus_a(bus_a), .bus_b(bus_b),
    .i_out(i_out), .q_out(q_out), .out_valid(out_valid), .frame_err(frame_err)
  );

  typedef struct {
    logic [15:0] i;
    logic [15:0] q;
    int unsigned at;
    string       tag;
  } exp_t;

  exp_t        expq[$];
  int unsigned cyc = 0;
  int          checks = 0;
  int          failures = 0;
  logic [15:0] last_i = '0;
  logic [15:0] last_q = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // driver: present one word for one cycle, pushing the pair it should yield
  task automatic drive(input logic [15:0] a, input logic [15:0] b, input logic s,
                       input bit yields, input logic [15:0] ei, input logic [15:0] eq,
                       input string tag);
    exp_t e;
    bus_a = a; bus_b = b; frame_stb = s;
    if (yields) begin
      e.i = ei; e.q = eq; e.at = cyc + 2; e.tag = tag;
      expq.push_back(e);
    end
    @(negedge clk);
  endtask

  // monitor: compare each produced pair, and the held value otherwise
  always @(negedge clk) begin
    if (cyc > 0 && rst_n) begin
      if (out_valid) begin
        if (expq.size() == 0) begin
          chk(0, "R3 unexpected out_valid", {i_out, q_out}, 32'h0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          chk({i_out, q_out} == {e.i, e.q}, e.tag, {i_out, q_out}, {e.i, e.q});
          chk(cyc == e.at, {e.tag, " timing"}, cyc, e.at);
          last_i = e.i; last_q = e.q;
        end
      end else begin
        chk({i_out, q_out} == {last_i, last_q}, "R3 hold", {i_out, q_out},
            {last_i, last_q});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({i_out, q_out} == 32'h0, "R1 data", {i_out, q_out}, 32'h0);
    chk(out_valid == 1'b0, "R1 valid", out_valid, 0);
    chk(frame_err == 1'b0, "R1 err", frame_err, 0);
    rst_n = 1'b1;
    drive(16'h0, 16'h0, 0, 0, 0, 0, "");

    // R2 / R3 parallel mode
    drive(16'h1111, 16'h2222, 1, 1, 16'h1111, 16'h2222, "R2");
    drive(16'h3333, 16'h4444, 1, 1, 16'h3333, 16'h4444, "R2");
    drive(16'h5555, 16'h6666, 0, 0, 0, 0, "");
    drive(16'h7777, 16'h8888, 1, 1, 16'h7777, 16'h8888, "R2");
    drive(16'h9999, 16'hAAAA, 0, 0, 0, 0, "");
    drive(16'hBBBB, 16'hCCCC, 0, 0, 0, 0, "");
    chk(frame_err == 1'b0, "R2 no err in parallel", frame_err, 0);

    // R4 / R5 / R7 interleaved, low word first; bus_b is noise
    cfg_single = 1'b1;
    drive(16'h0A01, 16'hDEAD, 0, 0, 0, 0, "");
    drive(16'h1A01, 16'hBEEF, 1, 1, 16'h1A01, 16'h0A01, "R5");
    drive(16'h0A02, 16'hF00D, 0, 0, 0, 0, "");
    drive(16'h1A02, 16'hCAFE, 1, 1, 16'h1A02, 16'h0A02, "R4");
    chk(frame_err == 1'b0, "R10 no err across mode change", frame_err, 0);

    // R8 repeated low: second low replaces held
    drive(16'h0B01, 16'h0, 0, 0, 0, 0, "");
    drive(16'h0B02, 16'h0, 0, 0, 0, 0, "");
    drive(16'h1B02, 16'h0, 1, 1, 16'h1B02, 16'h0B02, "R8");
    chk(frame_err == 1'b1, "R8 err on repeated low", frame_err, 1);
    // R8 repeated high: trailing word discarded
    drive(16'h0B03, 16'h0, 0, 0, 0, 0, "");
    drive(16'h1B03, 16'h0, 1, 1, 16'h1B03, 16'h0B03, "R7");
    drive(16'h1B04, 16'h0, 1, 0, 0, 0, "");
    drive(16'h0B05, 16'h0, 0, 0, 0, 0, "");
    drive(16'h1B05, 16'h0, 1, 1, 16'h1B05, 16'h0B05, "R8");
    chk(frame_err == 1'b1, "R9 err sticky", frame_err, 1);

    // R9 clear alone
    err_clr = 1'b1;
    drive(16'h0C01, 16'h0, 0, 0, 0, 0, "");
    err_clr = 1'b0;
    drive(16'h1C01, 16'h0, 1, 1, 16'h1C01, 16'h0C01, "R5");
    chk(frame_err == 1'b0, "R9 cleared", frame_err, 0);

    // R9 set and clear on the same edge: set wins
    drive(16'h0C02, 16'h0, 0, 0, 0, 0, "");
    drive(16'h0C03, 16'h0, 0, 0, 0, 0, "");
    err_clr = 1'b1;
    drive(16'h1C03, 16'h0, 1, 1, 16'h1C03, 16'h0C03, "R8");
    err_clr = 1'b0;
    chk(frame_err == 1'b1, "R9 set wins over clear", frame_err, 1);
    err_clr = 1'b1;
    drive(16'h0C04, 16'h0, 0, 0, 0, 0, "");
    err_clr = 1'b0;
    drive(16'h1C04, 16'h0, 1, 1, 16'h1C04, 16'h0C04, "R5");
    chk(frame_err == 1'b0, "R9 later clear", frame_err, 0);

    // R6 high word first; order change starts afresh (R10)
    cfg_q_first = 1'b1;
    drive(16'h1D01, 16'h5A5A, 1, 0, 0, 0, "");
    drive(16'h0D01, 16'hA5A5, 0, 1, 16'h1D01, 16'h0D01, "R6");
    drive(16'h1D02, 16'h0, 1, 0, 0, 0, "");
    drive(16'h0D02, 16'h0, 0, 1, 16'h1D02, 16'h0D02, "R6");
    chk(frame_err == 1'b0, "R10 no err across order change", frame_err, 0);
    drive(16'h1D03, 16'h0, 1, 0, 0, 0, "");
    drive(16'h1D04, 16'h0, 1, 0, 0, 0, "");
    drive(16'h0D04, 16'h0, 0, 1, 16'h1D04, 16'h0D04, "R8");
    chk(frame_err == 1'b1, "R8 err on repeated high", frame_err, 1);
    err_clr = 1'b1;
    drive(16'h1D05, 16'h0, 1, 0, 0, 0, "");
    err_clr = 1'b0;
    drive(16'h0D05, 16'h0, 0, 1, 16'h1D05, 16'h0D05, "R6");
    chk(frame_err == 1'b0, "R9 cleared again", frame_err, 0);

    // R10 held word dropped on order change
    drive(16'h1E01, 16'h0, 1, 0, 0, 0, "");
    cfg_q_first = 1'b0;
    drive(16'h0E01, 16'h0, 0, 0, 0, 0, "");
    drive(16'h1E02, 16'h0, 1, 1, 16'h1E02, 16'h0E01, "R10");
    chk(frame_err == 1'b0, "R10 no err after drop", frame_err, 0);

    // R10 held word dropped on mode change
    drive(16'h0E03, 16'h0, 0, 0, 0, 0, "");
    cfg_single = 1'b0;
    drive(16'h2E04, 16'h3E04, 1, 1, 16'h2E04, 16'h3E04, "R10");
    drive(16'h0, 16'h0, 0, 0, 0, 0, "");
    drive(16'h0, 16'h0, 0, 0, 0, 0, "");
    drive(16'h0, 16'h0, 0, 0, 0, 0, "");
    chk(expq.size() == 0, "R2 all pairs seen", expq.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule